// File: doc/BRIEF.md
# Embedded-Clock Serial Word Deserializer

This block receives one serial bit stream, already sampled on a fast bit clock, and turns it back into 10-bit parallel words together with a recovered word-rate clock and a lock flag. Each word travels inside a 12-bit frame. The frame starts with a 1 bit and ends with a 0 bit, so every frame boundary carries a 0-to-1 transition. The block uses that transition to find where words begin. The 10-bit word can carry one data byte plus two control bits. At a 40 MHz word rate it delivers 400 Mbps of payload.

Alignment comes from one of two sources. The first is a training frame of six ones followed by six zeros, which aligns the block at once. The second is ordinary payload traffic: the block locks once the boundary transition recurs at the same bit position for eight frames in a row. Until lock is held, the word output stays at zero and the recovered clock does not toggle. A select input picks whether data is meant to be taken on the rising or the falling edge of the recovered clock. A power-down input stops the block, and it starts again from the unlocked state.

The controller has four states. `ST_OFF` is taken whenever power-down is high, and it leaves to `ST_SEARCH` on the first edge with power-down low. `ST_SEARCH` goes to `ST_TRACK` on a boundary candidate, or straight to `ST_LOCKED` on the training frame. `ST_TRACK` goes to `ST_LOCKED` on the eighth confirmed boundary or on the training frame. It falls back to `ST_SEARCH` when a boundary is missing. `ST_LOCKED` falls back to `ST_SEARCH` after two missing boundaries in a row.

Top module: `deser_frame_rx`

## Requirements
- R1: A frame is sent first bit first as a start bit of 1, payload bits 9 down to 0, then a stop bit of 0. While locked, `word_out` shows that payload with payload bit 9 at `word_out[9]`.
- R2: With no training frame, `locked` rises at the clock edge that samples the eighth start bit found at the same position 12 bits apart. The first such start bit must follow a 0 bit. It does not rise after only seven.
- R3: When the last 12 sampled bits are 111111000000 (oldest first) and the block is not locked, `locked` rises at the edge that samples the final 0. The next bit is then taken as a start bit.
- R4: While locked, a frame whose start bit is not a 0-to-1 transition counts as missing. One missing boundary followed by a good one keeps lock. A second consecutive missing boundary drops `locked` at the edge that samples it.
- R5: While `locked` is low, `word_out` is zero and `word_clk` is low.
- R6: While locked, `word_out` takes a new payload at the edge that samples that frame's stop bit. It then holds for the next 12 bit cycles.
- R7: While locked with `edge_sel` = 0, `word_clk` goes high after the edge that samples frame bit 5 (start bit = 0) and low after the edge that samples the stop bit. With `edge_sel` = 1 the level is inverted, so data is taken on the falling edge.
- R8: While `pwr_dn` is high, `locked` is low from the next edge on and the outputs are zero. After release the block is unlocked and needs a fresh lock under R2 or R3.
- R9: After reset, `locked`, `word_out` and `word_clk` are all zero.
- R10: In search, a candidate boundary whose transition is missing 12 bits later is dropped. Search then resumes and `locked` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; halts the block and clears alignment |
| edge_sel | input | 1 | 0: data valid on rising edge of `word_clk`; 1: on falling edge |
| ser_in | input | 1 | Sampled serial bit |
| word_out | output | 10 | Recovered payload word |
| word_clk | output | 1 | Recovered word clock, stopped low when unlocked |
| locked | output | 1 | Word alignment established |

## Verification
Lock changes are due at the same rising edge that samples the deciding bit: the eighth start bit, the last zero of the training frame, or the second missing start bit. A new word is due at the edge that samples the stop bit. The recovered clock level is due at the edge that moves the frame position past bit 5 or past the stop bit. The bench drives one bit per falling edge and samples every output at the next falling edge. Each check therefore reads the outputs exactly one rising edge after the bit that should cause them. The reference model advances on that same rising edge.

// File: rtl/deser_pkg.sv
package deser_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SEARCH,
        ST_TRACK,
        ST_LOCKED
    } rx_state_e;

endpackage

// File: rtl/deser_hist.sv
// Serial history register with boundary-transition and training-frame detection.
module deser_hist #(
    parameter int FRAME_LEN = 12,
    parameter int WORD_W    = 10,
    parameter int SYNC_RUN  = FRAME_LEN / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              ser_in,
    output logic [WORD_W-1:0] payload,
    output logic              edge_seen,
    output logic              sync_seen
);
    localparam logic [FRAME_LEN-1:0] SYNC_PAT =
        {FRAME_LEN{1'b1}} << (FRAME_LEN - SYNC_RUN);

    logic [FRAME_LEN-1:0] hist_q;
    logic [FRAME_LEN-1:0] window;

    // Last FRAME_LEN bits including the one sampled at this edge.
    assign window    = {hist_q[FRAME_LEN-2:0], ser_in};
    assign edge_seen = ~hist_q[0] & ser_in;
    assign sync_seen = (window == SYNC_PAT);
    // Payload of a frame whose stop bit is on ser_in now.
    assign payload   = hist_q[WORD_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (pwr_dn) begin
            hist_q <= '0;
        end else begin
            hist_q <= window;
        end
    end

endmodule

// File: rtl/deser_fsm.sv
// Alignment controller: search, track candidate, locked, powered down.
module deser_fsm
    import deser_pkg::*;
#(
    parameter int FRAME_LEN   = 12,
    parameter int LOCK_FRAMES = 8,
    parameter int LOSS_FRAMES = 2,
    localparam int PH_W       = $clog2(FRAME_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_dn,
    input  logic            edge_seen,
    input  logic            sync_seen,
    output rx_state_e       state_q,
    output logic            lock_next,
    output logic [PH_W-1:0] ph_next,
    output logic            capture
);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
    localparam int MISS_W = $clog2(LOSS_FRAMES + 1);
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(FRAME_LEN - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_FRAMES - 1);

    rx_state_e         state_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    logic [GOOD_W-1:0] good_q, good_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              at_boundary;

    assign at_boundary = (ph_q == '0);

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            ph_q    <= '0;
            good_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            good_q  <= good_d;
            miss_q  <= miss_d;
        end
    end

    // Next-state process.
    always_comb begin
        state_d = state_q;
        ph_d    = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        good_d  = good_q;
        miss_d  = miss_q;
        if (pwr_dn) begin
            state_d = ST_OFF;
            ph_d    = '0;
            good_d  = '0;
            miss_d  = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_SEARCH;
                    ph_d    = '0;
                end
                ST_SEARCH: begin
                    ph_d = '0;
                    if (sync_seen) begin
                        state_d = ST_LOCKED;
                        miss_d  = '0;
                    end else if (edge_seen) begin
                        state_d = ST_TRACK;
                        ph_d    = PH_W'(1);
                        good_d  = GOOD_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (sync_seen) begin
                        state_d = ST_LOCKED;
                        ph_d    = '0;
                        miss_d  = '0;
                    end else if (at_boundary) begin
                        if (!edge_seen) begin
                            state_d = ST_SEARCH;
                            ph_d    = '0;
                            good_d  = '0;
                        end else if (good_q == GOOD_LAST) begin
                            state_d = ST_LOCKED;
                            miss_d  = '0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_boundary) begin
                        if (edge_seen) begin
                            miss_d = '0;
                        end else if (miss_q == MISS_LAST) begin
                            state_d = ST_SEARCH;
                            ph_d    = '0;
                            good_d  = '0;
                            miss_d  = '0;
                        end else begin
                            miss_d = miss_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Output process.
    always_comb begin
        lock_next = (state_d == ST_LOCKED);
        ph_next   = ph_d;
        capture   = (state_q == ST_LOCKED) && (ph_q == PH_LAST) && !pwr_dn;
    end

endmodule

// File: rtl/deser_out.sv
// Word register and recovered word-clock generator.
module deser_out #(
    parameter int WORD_W    = 10,
    parameter int FRAME_LEN = 12,
    localparam int PH_W     = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] payload,
    input  logic              capture,
    input  logic              lock_next,
    input  logic [PH_W-1:0]   ph_next,
    input  logic              edge_sel,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk
);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(FRAME_LEN / 2);

    logic [WORD_W-1:0] word_d;
    logic              clk_d;

    always_comb begin
        if (!lock_next) begin
            word_d = '0;
        end else if (capture) begin
            word_d = payload;
        end else begin
            word_d = word_out;
        end
        clk_d = lock_next & ((ph_next >= PH_HALF) ^ edge_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out <= '0;
            word_clk <= 1'b0;
        end else begin
            word_out <= word_d;
            word_clk <= clk_d;
        end
    end

endmodule

// File: rtl/deser_frame_rx.sv
// Top: serial frame deserializer with random-data and training-frame lock.
module deser_frame_rx
    import deser_pkg::*;
#(
    parameter int WORD_W      = 10,
    parameter int LOCK_FRAMES = 8,
    parameter int LOSS_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              edge_sel,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk,
    output logic              locked
);
    localparam int FRAME_LEN = WORD_W + 2;
    localparam int PH_W      = $clog2(FRAME_LEN);

    logic [WORD_W-1:0] payload;
    logic              edge_seen;
    logic              sync_seen;
    rx_state_e         state_q;
    logic              lock_next;
    logic [PH_W-1:0]   ph_next;
    logic              capture;

    deser_hist #(
        .FRAME_LEN (FRAME_LEN),
        .WORD_W    (WORD_W)
    ) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .ser_in    (ser_in),
        .payload   (payload),
        .edge_seen (edge_seen),
        .sync_seen (sync_seen)
    );

    deser_fsm #(
        .FRAME_LEN   (FRAME_LEN),
        .LOCK_FRAMES (LOCK_FRAMES),
        .LOSS_FRAMES (LOSS_FRAMES)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .edge_seen (edge_seen),
        .sync_seen (sync_seen),
        .state_q   (state_q),
        .lock_next (lock_next),
        .ph_next   (ph_next),
        .capture   (capture)
    );

    deser_out #(
        .WORD_W    (WORD_W),
        .FRAME_LEN (FRAME_LEN)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .payload   (payload),
        .capture   (capture),
        .lock_next (lock_next),
        .ph_next   (ph_next),
        .edge_sel  (edge_sel),
        .word_out  (word_out),
        .word_clk  (word_clk)
    );

    assign locked = (state_q == ST_LOCKED);

endmodule

// File: rtl/deser_frame_rx_chk.sv
// Port-level properties of the deserializer, bound to the top module.
module deser_frame_rx_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_dn,
    input logic              edge_sel,
    input logic [WORD_W-1:0] word_out,
    input logic              word_clk,
    input logic              locked
);
    // R5: outputs quiet while unlocked
    assert_quiet_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (word_out == '0) && !word_clk);

    // R8: power-down removes lock at the next edge
    assert_pwrdn_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !locked);

    // R8: lock cannot be gained from an edge sampled in power-down
    assert_lock_after_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> !$past(pwr_dn));

    // R6: a new word while locked always comes with a word-clock transition
    assert_word_with_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked) && $stable(edge_sel) && !$stable(word_out))
            |-> !$stable(word_clk));

endmodule

bind deser_frame_rx deser_frame_rx_chk #(.WORD_W(WORD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .edge_sel (edge_sel),
    .word_out (word_out),
    .word_clk (word_clk),
    .locked   (locked)
);

// File: tb/deser_frame_rx_tb_top.sv
module deser_frame_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       edge_sel = 1'b0;
    logic       ser_in = 1'b0;
    logic [9:0] word_out;
    logic       word_clk;
    logic       locked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    deser_frame_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .edge_sel (edge_sel),
        .ser_in   (ser_in),
        .word_out (word_out),
        .word_clk (word_clk),
        .locked   (locked)
    );

    // Behavioural reference model: 0 off, 1 search, 2 candidate, 3 aligned.
    bit       hq[$];
    int       m_mode = 1;
    int       m_pos = 0;
    int       m_good = 0;
    int       m_miss = 0;
    bit [9:0] m_word = '0;
    bit       m_clk = 1'b0;
    bit       m_edge;
    bit       m_sync;
    bit [11:0] m_win;
    bit [9:0] m_pay;

    initial begin
        for (int i = 0; i < 12; i++) hq.push_back(1'b0);
    end

    always @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            for (int i = 0; i < 12; i++) hq[i] = 1'b0;
            m_mode = rst_n ? 0 : 1;
            m_pos = 0; m_good = 0; m_miss = 0;
        end else begin
            m_edge = !hq[11] && ser_in;
            for (int i = 0; i < 11; i++) m_win[11 - i] = hq[i + 1];
            m_win[0] = ser_in;
            m_sync = (m_win == 12'b111111000000);
            for (int i = 0; i < 10; i++) m_pay[9 - i] = hq[i + 2];
            if (m_mode == 0) begin
                m_mode = 1; m_pos = 0;
            end else if (m_mode != 3 && m_sync) begin
                m_mode = 3; m_pos = 0; m_miss = 0;
            end else if (m_mode == 1) begin
                if (m_edge) begin m_mode = 2; m_pos = 1; m_good = 1; end
            end else if (m_mode == 2) begin
                if (m_pos == 0 && !m_edge) begin
                    m_mode = 1; m_pos = 0;
                end else begin
                    if (m_pos == 0) m_good++;
                    if (m_good == 8) begin m_mode = 3; m_miss = 0; end
                    m_pos = (m_pos + 1) % 12;
                end
            end else begin
                if (m_pos == 11) m_word = m_pay;
                if (m_pos == 0) begin
                    if (m_edge) m_miss = 0;
                    else m_miss++;
                end
                if (m_miss == 2) begin
                    m_mode = 1; m_pos = 0; m_miss = 0;
                end else begin
                    m_pos = (m_pos + 1) % 12;
                end
            end
            hq.push_back(ser_in);
            void'(hq.pop_front());
        end
        if (m_mode != 3) m_word = '0;
        m_clk = (m_mode == 3) && ((m_pos >= 6) != edge_sel);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        chk(locked === (m_mode == 3), "R2", "locked vs model", int'(locked), int'(m_mode == 3));
        chk(word_out === m_word, "R1", "word_out vs model", int'(word_out), int'(m_word));
        chk(word_clk === m_clk, "R7", "word_clk vs model", int'(word_clk), int'(m_clk));
    endtask

    // Drive one bit at a falling edge; return at the next falling edge after checking.
    task automatic send_bit(input bit b);
        ser_in = b;
        @(negedge clk);
        compare_model();
    endtask

    task automatic send_frame(input bit start, input bit [9:0] w);
        send_bit(start);
        for (int i = 9; i >= 0; i--) send_bit(w[i]);
        send_bit(1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    bit [9:0] words [10];

    initial begin
        words = '{10'h2A5, 10'h155, 10'h0F3, 10'h19C, 10'h2D2,
                  10'h0B4, 10'h36A, 10'h1C7, 10'h2B9, 10'h0CD};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(locked === 1'b0, "R9", "locked after reset", int'(locked), 0);
        chk(word_out === '0, "R9", "word_out after reset", int'(word_out), 0);
        chk(word_clk === 1'b0, "R9", "word_clk after reset", int'(word_clk), 0);
        idle(4);

        // R10: lone candidate without a repeat is dropped
        send_bit(1'b1);
        idle(12);
        chk(locked === 1'b0, "R10", "locked after failed candidate", int'(locked), 0);
        idle(3);

        // R2: random-data lock after eight aligned boundaries
        for (int f = 0; f < 7; f++) send_frame(1'b1, words[f]);
        chk(locked === 1'b0, "R2", "locked after seven frames", int'(locked), 0);
        chk(word_out === '0, "R5", "word_out while unlocked", int'(word_out), 0);
        send_bit(1'b1);
        chk(locked === 1'b1, "R2", "locked at eighth start bit", int'(locked), 1);
        for (int i = 9; i >= 0; i--) send_bit(words[7][i]);
        send_bit(1'b0);
        chk(word_out === words[7], "R1", "first word after lock", int'(word_out), int'(words[7]));

        // R6 / R7: word hold and clock phase within a frame
        send_bit(1'b1);
        chk(word_clk === 1'b0, "R7", "clock low after start bit", int'(word_clk), 0);
        chk(word_out === words[7], "R6", "word held into next frame", int'(word_out), int'(words[7]));
        for (int i = 9; i >= 4; i--) send_bit(words[8][i]);
        chk(word_clk === 1'b1, "R7", "clock high after bit 6", int'(word_clk), 1);
        for (int i = 3; i >= 0; i--) send_bit(words[8][i]);
        send_bit(1'b0);
        chk(word_out === words[8], "R6", "word at stop bit", int'(word_out), int'(words[8]));
        chk(word_clk === 1'b0, "R7", "clock low after stop bit", int'(word_clk), 0);

        // R7: falling-edge selection inverts the clock
        edge_sel = 1'b1;
        send_bit(1'b1);
        chk(word_clk === 1'b1, "R7", "inverted clock after start bit", int'(word_clk), 1);
        for (int i = 9; i >= 0; i--) send_bit(words[9][i]);
        send_bit(1'b0);
        chk(word_out === words[9], "R1", "word with edge_sel=1", int'(word_out), int'(words[9]));
        edge_sel = 1'b0;

        // R4: one missing boundary tolerated, two drop lock
        send_frame(1'b0, 10'h155);
        send_frame(1'b1, 10'h0F3);
        chk(locked === 1'b1, "R4", "lock kept after single miss", int'(locked), 1);
        chk(word_out === 10'h0F3, "R4", "word after single miss", int'(word_out), 'h0F3);
        send_frame(1'b0, 10'h19C);
        send_bit(1'b0);
        chk(locked === 1'b0, "R4", "lock lost at second miss", int'(locked), 0);
        chk(word_out === '0, "R5", "word cleared on loss", int'(word_out), 0);
        for (int i = 9; i >= 0; i--) send_bit(1'b0);
        send_bit(1'b0);

        // R3: training frame aligns immediately
        idle(13);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        chk(locked === 1'b0, "R3", "locked before last sync bit", int'(locked), 0);
        send_bit(1'b0);
        chk(locked === 1'b1, "R3", "locked at last sync bit", int'(locked), 1);
        send_frame(1'b1, 10'h2A5);
        chk(word_out === 10'h2A5, "R3", "word after sync lock", int'(word_out), 'h2A5);

        // R8: power-down and restart
        pwr_dn = 1'b1;
        idle(5);
        chk(locked === 1'b0, "R8", "locked in power-down", int'(locked), 0);
        chk(word_out === '0, "R8", "word in power-down", int'(word_out), 0);
        chk(word_clk === 1'b0, "R8", "clock in power-down", int'(word_clk), 0);
        pwr_dn = 1'b0;
        idle(3);
        send_frame(1'b1, 10'h36A);
        chk(locked === 1'b0, "R8", "unlocked after release", int'(locked), 0);
        for (int f = 0; f < 7; f++) send_frame(1'b1, words[f]);
        chk(locked === 1'b1, "R8", "relocked after release", int'(locked), 1);
        chk(word_out === words[6], "R8", "word after relock", int'(word_out), int'(words[6]));
        idle(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule